// File: doc/BRIEF.md
# I2C Write-Path Address Filter

This block is the receive half of a byte-oriented I2C target for a peripheral that is mostly written to. A fast system clock samples SCL and SDA through two-flop synchronizers. The block detects START and STOP conditions and assembles bytes MSB first. It then decides whether the first byte after a START names this device.

Two address patterns are recognised:
- A device address made of a fixed five-bit prefix, one select bit, and a fixed zero. The select bit must equal the level of a select pin, and that level is latched while reset is held.
- A broadcast address, set by a parameter, that is accepted for writes whatever level the select pin has.

Each accepted byte is acknowledged by pulling SDA low through an open-drain enable. The byte goes to downstream logic with a one-cycle strobe and a byte index: 0 for the address, then 1, 2 and so on for data bytes. A separate one-cycle pulse marks the release of every acknowledge the block drives. Downstream logic can use that pulse as its update instant.

Top module: `i2c_addr_filter`

## Requirements
- R1: While reset is held and after it, `sda_drive_low`, `byte_valid` and `ack_fall` are 0. Bytes clocked before any START are not acknowledged.
- R2: The first byte after START is accepted when bits [7:3] are 5'b10011, bit [2] equals the latched select level and bit [1] is 0, with either value of bit [0] (R/W).
- R3: The select level is the value of `sel_pin` sampled while `rst_n` is low. Changes of `sel_pin` after reset have no effect until the next reset.
- R4: An address byte whose bits [7:1] equal `BCAST_ADDR` (default 7'b1001000) is accepted with bit [0] = 0 (write) regardless of the select level. With bit [0] = 1 it is not acknowledged.
- R5: An address byte that matches neither pattern is not acknowledged and produces no strobe. All further bytes are ignored until the next START.
- R6: Every acknowledged byte gives one `byte_valid` pulse carrying the byte on `byte_data` and its index on `byte_idx`. The address byte has index 0 and data bytes count up from 1, saturating at 2^IDX_W-1.
- R7: After an own-address byte with R/W = 1 is acknowledged, later bytes are not acknowledged until the next START.
- R8: `ack_fall` pulses for one cycle when each driven acknowledge is released, once per acknowledged byte.
- R9: A STOP (SDA rising while SCL high) ends the transfer. Bytes clocked after it are not acknowledged.
- R10: A repeated START (no STOP) restarts address matching, including after a rejected address.
- R11: During an acknowledge, SDA is held low across the whole high phase of the ninth SCL pulse. It is released only after SCL falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset; the select pin is sampled while low |
| sel_pin | input | 1 | Address select level |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| byte_valid | output | 1 | One-cycle strobe for an acknowledged byte |
| byte_data | output | 8 | Byte presented with the strobe |
| byte_idx | output | IDX_W | Position of the byte after START (0 = address) |
| ack_fall | output | 1 | One-cycle pulse when an acknowledge is released |

## Verification
The hardest situation to reach is the latched select level disagreeing with the live pin. This requires changing `sel_pin` after reset and then issuing a second reset with the new level. The bench does exactly that and checks that the acceptance of the two device addresses swaps, while the broadcast write is accepted both times. A second hard case is a repeated START that follows a rejected address, because the block must leave its ignoring state without any STOP in between. The bench also clocks a byte after a STOP without a new START to show that no acknowledge appears.

// File: rtl/i2c_addr_filter.sv
module i2c_addr_filter #(
  parameter logic [4:0] PREFIX     = 5'b10011,
  parameter logic [6:0] BCAST_ADDR = 7'b1001000,
  parameter int         IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_pin,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_drive_low,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx,
  output logic             ack_fall
);

  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_RX, S_WAIT_ACK, S_ACK} st_t;

  st_t              st;
  logic [1:0]       scl_sy, sda_sy;
  logic             scl_d, sda_d, sel_q;
  logic [2:0]       bitcnt;
  logic [7:0]       sr;
  logic             first_q, rd_q;
  logic [IDX_W-1:0] idx_q;

  logic scl_s, sda_s, start_c, stop_c, scl_rise, scl_fall;
  logic own_hit, bc_hit, accept;
  logic [7:0] full;

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;

  assign full    = {sr[6:0], sda_s};
  assign own_hit = (full[7:3] == PREFIX) && (full[2] == sel_q) && !full[1];
  assign bc_hit  = (full[7:1] == BCAST_ADDR) && !full[0];
  assign accept  = !first_q || own_hit || bc_hit;

  assign sda_drive_low = (st == S_ACK);

  always_ff @(posedge clk)
    if (!rst_n) sel_q <= sel_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy     <= 2'b11;
      sda_sy     <= 2'b11;
      scl_d      <= 1'b1;
      sda_d      <= 1'b1;
      st         <= S_IDLE;
      bitcnt     <= '0;
      sr         <= '0;
      first_q    <= 1'b0;
      rd_q       <= 1'b0;
      idx_q      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_idx   <= '0;
      ack_fall   <= 1'b0;
    end else begin
      scl_sy     <= {scl_sy[0], scl_in};
      sda_sy     <= {sda_sy[0], sda_in};
      scl_d      <= scl_s;
      sda_d      <= sda_s;
      byte_valid <= 1'b0;
      ack_fall   <= 1'b0;
      if (start_c) begin
        st      <= S_RX;
        bitcnt  <= '0;
        first_q <= 1'b1;
        rd_q    <= 1'b0;
        idx_q   <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            sr     <= full;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              if (accept) begin
                st <= S_WAIT_ACK;
                if (first_q) rd_q <= full[0];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_WAIT_ACK: if (scl_fall) begin
            st         <= S_ACK;
            byte_valid <= 1'b1;
            byte_data  <= sr;
            byte_idx   <= idx_q;
          end
          S_ACK: if (scl_fall) begin
            ack_fall <= 1'b1;
            bitcnt   <= '0;
            first_q  <= 1'b0;
            if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
            st <= rd_q ? S_IDLE : S_RX;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_addr_filter_chk.sv
module i2c_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic drv,
  input logic valid,
  input logic afall,
  input logic scl_fall,
  input logic bus_evt,
  input logic idle
);

  // R8
  a_r8_pulse_ends_drive: assert property (@(posedge clk) disable iff (!rst_n)
    afall |-> (!drv && $past(drv)));

  // R8
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    afall |-> !valid);

  // R6
  a_r6_strobe_opens_ack: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (drv && !$past(drv)));

  // R11
  a_r11_release_after_scl_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv) |-> ($past(scl_fall) || $past(bus_evt)));

  // R5
  a_r5_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!drv && !valid));

endmodule

bind i2c_addr_filter i2c_addr_filter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .drv      (sda_drive_low),
  .valid    (byte_valid),
  .afall    (ack_fall),
  .scl_fall (scl_fall),
  .bus_evt  (start_c | stop_c),
  .idle     (st == S_IDLE)
);

// File: tb/test_i2c_addr_filter.sv
`timescale 1ns/1ps
module test_i2c_addr_filter;
  localparam int IDX_W = 4;
  localparam int Q = 8;
  localparam int H = 16;

  logic clk = 0, rst_n = 0, sel_pin = 0, scl = 1, sda_m = 1;
  logic sda_drive_low, byte_valid, ack_fall;
  logic [7:0] byte_data;
  logic [IDX_W-1:0] byte_idx;
  logic sda_line;

  int checks = 0, errors = 0;
  int n_strobe = 0, n_af = 0;
  logic [7:0] last_data = 0;
  logic [IDX_W-1:0] last_idx = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_drive_low;

  i2c_addr_filter #(.IDX_W(IDX_W)) i_i2c_addr_filter (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .scl_in(scl), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_idx(byte_idx), .ack_fall(ack_fall));

  always @(negedge clk) begin
    if (byte_valid) begin
      n_strobe++;
      last_data = byte_data;
      last_idx  = byte_idx;
    end
    if (ack_fall) n_af++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    scl = 1; sda_m = 1; sel_pin = sel; rst_n = 0;
    tick(4);
    rst_n = 1;
    tick(4);
  endtask

  task automatic start_cond();
    sda_m = 1; tick(Q);
    scl = 1; tick(Q);
    sda_m = 0; tick(Q);
    scl = 0; tick(Q);
  endtask

  task automatic stop_cond();
    scl = 0; tick(Q);
    sda_m = 0; tick(Q);
    scl = 1; tick(Q);
    sda_m = 1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit early, late;
    scl = 0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = b[i];
      tick(Q); scl = 1;
      tick(H); scl = 0;
    end
    tick(Q); sda_m = 1;
    tick(Q); scl = 1;
    tick(2);     early = !sda_line;
    tick(H - 4); late  = !sda_line;
    tick(2); scl = 0;
    tick(Q);
    chk(early == late, "R11 ack held over high phase", early, late);
    ack = early && late;
  endtask

  task automatic expect_ack(input logic [7:0] b, input bit exp, input string req);
    bit a;
    send_byte(b, a);
    chk(a == exp, req, a, exp);
  endtask

  task automatic t_reset();
    do_reset(0);
    chk(sda_drive_low == 0 && byte_valid == 0 && ack_fall == 0, "R1 reset outputs",
        {sda_drive_low, byte_valid, ack_fall}, 0);
    expect_ack(8'h98, 0, "R1 no ack before START");
    chk(n_strobe == 0, "R1 no strobe before START", n_strobe, 0);
  endtask

  task automatic t_own_write();
    int s0 = n_strobe, a0 = n_af;
    start_cond();
    expect_ack(8'h98, 1, "R2 own write address");
    chk(last_data == 8'h98 && last_idx == 0, "R6 address strobe", {last_idx, last_data}, 16'h0098);
    expect_ack(8'h12, 1, "R6 data byte 1");
    chk(last_data == 8'h12 && last_idx == 1, "R6 data byte 1 strobe", {last_idx, last_data}, 16'h0112);
    expect_ack(8'h34, 1, "R6 data byte 2");
    chk(last_data == 8'h34 && last_idx == 2, "R6 data byte 2 strobe", {last_idx, last_data}, 16'h0234);
    chk(n_strobe - s0 == 3, "R6 strobe count", n_strobe - s0, 3);
    chk(n_af - a0 == 3, "R8 ack_fall count", n_af - a0, 3);
    stop_cond();
  endtask

  task automatic t_mismatch();
    int s0 = n_strobe, a0 = n_af;
    start_cond();
    expect_ack(8'h9C, 0, "R5 wrong select bit");
    expect_ack(8'h55, 0, "R5 later byte ignored");
    start_cond();
    expect_ack(8'h18, 0, "R2 wrong prefix");
    start_cond();
    expect_ack(8'h9A, 0, "R2 fixed zero bit set");
    chk(n_strobe == s0 && n_af == a0, "R5 no strobe or ack_fall", n_strobe - s0, 0);
    stop_cond();
  endtask

  task automatic t_bcast();
    start_cond();
    expect_ack(8'h90, 1, "R4 broadcast write");
    expect_ack(8'h77, 1, "R4 broadcast data");
    chk(last_data == 8'h77 && last_idx == 1, "R6 broadcast data strobe", {last_idx, last_data}, 16'h0177);
    stop_cond();
    start_cond();
    expect_ack(8'h91, 0, "R4 broadcast read rejected");
    stop_cond();
  endtask

  task automatic t_read();
    start_cond();
    expect_ack(8'h99, 1, "R7 own read address");
    chk(last_data == 8'h99 && last_idx == 0, "R7 read address strobe", {last_idx, last_data}, 16'h0099);
    expect_ack(8'h00, 0, "R7 bytes after read ignored");
    stop_cond();
  endtask

  task automatic t_restart();
    start_cond();
    expect_ack(8'h9C, 0, "R10 rejected before restart");
    start_cond();
    expect_ack(8'h98, 1, "R10 repeated START matches");
    expect_ack(8'h5A, 1, "R10 data after restart");
    start_cond();
    expect_ack(8'h90, 1, "R10 restart without STOP");
    stop_cond();
  endtask

  task automatic t_stop();
    start_cond();
    expect_ack(8'h98, 1, "R9 address before STOP");
    stop_cond();
    expect_ack(8'h12, 0, "R9 byte after STOP ignored");
    stop_cond();
  endtask

  task automatic t_sel_latched();
    sel_pin = 1;
    start_cond();
    expect_ack(8'h9C, 0, "R3 live pin change ignored");
    start_cond();
    expect_ack(8'h98, 1, "R3 latched select kept");
    stop_cond();
    do_reset(1);
    start_cond();
    expect_ack(8'h9C, 1, "R3 new latched select");
    start_cond();
    expect_ack(8'h98, 0, "R3 old select rejected");
    start_cond();
    expect_ack(8'h90, 1, "R4 broadcast with select 1");
    stop_cond();
    sel_pin = 0;
  endtask

  task automatic t_saturate();
    start_cond();
    expect_ack(8'h9C, 1, "R6 address for saturation");
    for (int k = 1; k <= 17; k++) expect_ack(8'(k), 1, "R6 long write");
    chk(last_idx == 4'hF && last_data == 8'd17, "R6 index saturates", last_idx, 15);
    stop_cond();
  endtask

  initial begin
    t_reset();
    t_own_write();
    t_mismatch();
    t_bcast();
    t_read();
    t_restart();
    t_stop();
    t_sel_latched();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule